// File: doc/BRIEF.md
# Floating-Point Overflow and Underflow Result Fixup

This block sits after a single-precision arithmetic unit. For each result it decides what goes to the destination register and whether that register is written. It also keeps sticky exception flags and requests a trap when an exception has to be handled by software. The unit supplies the sign of the result, overflow and underflow indications, and its normal 32-bit result. Alongside each result come the rounding mode and three control bits: overflow trap enable, underflow trap enable and denormal flush.

On a masked overflow, the rounding direction and the sign together select either the largest finite value or infinity. When a trap is enabled, the destination is left untouched. A masked underflow either writes a signed zero or, when flushing is off, escalates to an unimplemented-operation exception.

Results travel on a valid/ready stream with one output register. A result is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds steady and no new result is taken.

Top module: `fpfx_handler`

## Requirements
- R1: An input is accepted on a clock edge where `in_valid` and `in_ready` are both high, with `in_ready` = !`out_valid` || `out_ready`. Its outcome appears on `out_valid`/`out_data`/`out_we` after that edge. It holds unchanged while `out_ready` is low.
- R2: With neither overflow nor underflow flagged, `out_data` equals `in_data`, `out_we` is 1, no flag is set and no trap is requested.
- R3: On a masked overflow (`ovf_trap_en`=0), `out_data` is infinity (7F800000/FF800000) or the largest finite value (7F7FFFFF/FF7FFFFF) of the result's sign, chosen by `rnd_mode` (00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf). The choices are: nearest gives infinity; toward zero gives the largest finite value; toward +inf gives +inf for positive and the largest finite negative for negative; toward -inf gives the largest finite positive for positive and -inf for negative.
- R4: A masked overflow writes (`out_we`=1), sets the overflow and inexact flags, and requests no trap.
- R5: An enabled overflow does not write, sets the overflow flag and requests a trap.
- R6: A masked underflow with `flush_dn`=1 writes a zero carrying the result's sign (00000000 or 80000000), sets the underflow flag and requests no trap.
- R7: A masked underflow with `flush_dn`=0 does not write, sets the underflow and unimplemented flags and requests a trap.
- R8: An enabled underflow does not write, sets the underflow flag and requests a trap, whatever `flush_dn` is.
- R9: When overflow and underflow are both flagged, the overflow handling applies and the underflow flag is not set.
- R10: `flags` bits are [0] overflow, [1] underflow, [2] inexact, [3] unimplemented. They are sticky and are cleared only by `flags_clr` on a clock edge. A bit set by a result accepted on the same edge as a clear ends up set.
- R11: `trap_req` is high for exactly the one cycle after the accepting edge of a trapping result, and never with `out_we`.
- R12: After reset, `out_valid`, `out_we`, `trap_req` and `flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Result from the arithmetic unit is present |
| in_ready | output | 1 | Block can take a result this cycle |
| in_sign | input | 1 | Sign of the exact result |
| in_ovf | input | 1 | Result overflowed |
| in_udf | input | 1 | Result underflowed |
| in_data | input | 32 | Normal rounded result |
| rnd_mode | input | 2 | Rounding mode, encoding per R3 |
| ovf_trap_en | input | 1 | Overflow trap enable |
| udf_trap_en | input | 1 | Underflow trap enable |
| flush_dn | input | 1 | Flush underflow to zero |
| out_valid | output | 1 | Outcome held in output register |
| out_ready | input | 1 | Consumer takes the outcome |
| out_data | output | 32 | Value for the destination register |
| out_we | output | 1 | Destination write enable |
| flags_clr | input | 1 | Synchronous clear of sticky flags |
| flags | output | 4 | Sticky exception flags |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The hardest situation to reach is a clear that coincides with a new exception. It needs `flags_clr` and an accepted result on the same edge. The bench drives both in the same cycle after other flags are already set, then checks that only the new bits remain. A second hard case is a result that arrives while the output is stalled. The bench holds `out_ready` low, offers a second result, and checks that it is refused and then taken on the draining edge.

// File: rtl/fpfx_pkg.sv
package fpfx_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_PLUS    = 2'b10,
    RM_MINUS   = 2'b11
  } rmode_e;

  localparam int FLG_OVF = 0;
  localparam int FLG_UDF = 1;
  localparam int FLG_INX = 2;
  localparam int FLG_UIM = 3;
  localparam int NFLG    = 4;
endpackage

// File: rtl/fpfx_ovf_sel.sv
module fpfx_ovf_sel
  import fpfx_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         sign,
  input  logic [1:0]   mode,
  output logic [W-1:0] sat_val
);
  logic to_inf;
  logic [W-1:0] inf_val;
  logic [W-1:0] max_val;

  always_comb begin
    unique case (rmode_e'(mode))
      RM_NEAREST: to_inf = 1'b1;
      RM_ZERO:    to_inf = 1'b0;
      RM_PLUS:    to_inf = !sign;
      RM_MINUS:   to_inf = sign;
      default:    to_inf = 1'b1;
    endcase
    inf_val = {sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    max_val = {sign, {(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};
    sat_val = to_inf ? inf_val : max_val;
  end
endmodule

// File: rtl/fpfx_decide.sv
module fpfx_decide
  import fpfx_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic            sign,
  input  logic            ovf,
  input  logic            udf,
  input  logic [1:0]      mode,
  input  logic            ovf_en,
  input  logic            udf_en,
  input  logic            dn,
  input  logic [W-1:0]    data,
  output logic [W-1:0]    res_data,
  output logic            res_we,
  output logic            res_trap,
  output logic [NFLG-1:0] res_flags
);
  logic [W-1:0] sat_val;

  fpfx_ovf_sel #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sel (
    .sign    (sign),
    .mode    (mode),
    .sat_val (sat_val)
  );

  always_comb begin
    res_data  = data;
    res_we    = 1'b1;
    res_trap  = 1'b0;
    res_flags = '0;
    if (ovf) begin
      res_flags[FLG_OVF] = 1'b1;
      if (ovf_en) begin
        res_we   = 1'b0;
        res_trap = 1'b1;
      end else begin
        res_data           = sat_val;
        res_flags[FLG_INX] = 1'b1;
      end
    end else if (udf) begin
      res_flags[FLG_UDF] = 1'b1;
      if (udf_en) begin
        res_we   = 1'b0;
        res_trap = 1'b1;
      end else if (dn) begin
        res_data = {sign, {(W-1){1'b0}}};
      end else begin
        res_we             = 1'b0;
        res_trap           = 1'b1;
        res_flags[FLG_UIM] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpfx_status.sv
module fpfx_status
  import fpfx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [NFLG-1:0] set_bits,
  input  logic            trap_in,
  input  logic            clr,
  output logic [NFLG-1:0] flags,
  output logic            trap_req
);
  for (genvar g = 0; g < NFLG; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    flags[g] <= 1'b0;
      else if (set_en && set_bits[g]) flags[g] <= 1'b1;
      else if (clr)                  flags[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_req <= 1'b0;
    else        trap_req <= set_en && trap_in;
  end
endmodule

// File: rtl/fpfx_handler.sv
module fpfx_handler
  import fpfx_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_sign,
  input  logic            in_ovf,
  input  logic            in_udf,
  input  logic [W-1:0]    in_data,
  input  logic [1:0]      rnd_mode,
  input  logic            ovf_trap_en,
  input  logic            udf_trap_en,
  input  logic            flush_dn,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_data,
  output logic            out_we,
  input  logic            flags_clr,
  output logic [NFLG-1:0] flags,
  output logic            trap_req
);
  logic            accept;
  logic [W-1:0]    d_data;
  logic            d_we;
  logic            d_trap;
  logic [NFLG-1:0] d_flags;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  fpfx_decide #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dec (
    .sign      (in_sign),
    .ovf       (in_ovf),
    .udf       (in_udf),
    .mode      (rnd_mode),
    .ovf_en    (ovf_trap_en),
    .udf_en    (udf_trap_en),
    .dn        (flush_dn),
    .data      (in_data),
    .res_data  (d_data),
    .res_we    (d_we),
    .res_trap  (d_trap),
    .res_flags (d_flags)
  );

  fpfx_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (accept),
    .set_bits (d_flags),
    .trap_in  (d_trap),
    .clr      (flags_clr),
    .flags    (flags),
    .trap_req (trap_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_we    <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= d_data;
      out_we    <= d_we;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_we    <= 1'b0;
    end
  end
endmodule

// File: rtl/fpfx_handler_chk.sv
module fpfx_handler_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_ovf,
  input logic        in_udf,
  input logic [31:0] in_data,
  input logic        ovf_trap_en,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_we,
  input logic        flags_clr,
  input logic [3:0]  flags,
  input logic        trap_req
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r1_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_we));

  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_ovf && !in_udf |=> out_we && out_data == $past(in_data));

  a_r4_masked_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_ovf && !ovf_trap_en |=> flags[2] && flags[0] && out_we);

  a_r5_enabled_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_ovf && ovf_trap_en |=> !out_we && trap_req);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_clr |=> ((flags & $past(flags)) == $past(flags)));

  a_r11_trap_excl_write: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> out_valid && !out_we);
endmodule

bind fpfx_handler fpfx_handler_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_ovf(in_ovf), .in_udf(in_udf), .in_data(in_data),
  .ovf_trap_en(ovf_trap_en), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_we(out_we), .flags_clr(flags_clr),
  .flags(flags), .trap_req(trap_req)
);

// File: tb/fpfx_handler_tb_top.sv
module fpfx_handler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sign = 1'b0;
  logic        in_ovf = 1'b0;
  logic        in_udf = 1'b0;
  logic [31:0] in_data = '0;
  logic [1:0]  rnd_mode = 2'b00;
  logic        ovf_trap_en = 1'b0;
  logic        udf_trap_en = 1'b0;
  logic        flush_dn = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_we;
  logic        flags_clr = 1'b0;
  logic [3:0]  flags;
  logic        trap_req;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = !clk;

  fpfx_handler dut_i (.*);

  // {sign, ovf, udf, mode, oen, uen, dn, data, exp_data, exp_we, exp_trap, exp_flags}
  typedef struct packed {
    logic        s, o, u;
    logic [1:0]  m;
    logic        oe, ue, dn;
    logic [31:0] d, xd;
    logic        xwe, xtr;
    logic [3:0]  xf;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    {1'b0,1'b0,1'b0,2'b00,1'b0,1'b0,1'b0,32'h3F800000,32'h3F800000,1'b1,1'b0,4'b0000}, // R2
    {1'b1,1'b0,1'b0,2'b11,1'b1,1'b1,1'b0,32'hC0490FDB,32'hC0490FDB,1'b1,1'b0,4'b0000}, // R2
    {1'b0,1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,32'h12345678,32'h7F800000,1'b1,1'b0,4'b0101}, // R3 R4
    {1'b1,1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,32'h12345678,32'hFF800000,1'b1,1'b0,4'b0101}, // R3
    {1'b0,1'b1,1'b0,2'b01,1'b0,1'b0,1'b0,32'h12345678,32'h7F7FFFFF,1'b1,1'b0,4'b0101}, // R3
    {1'b1,1'b1,1'b0,2'b01,1'b0,1'b0,1'b0,32'h12345678,32'hFF7FFFFF,1'b1,1'b0,4'b0101}, // R3
    {1'b0,1'b1,1'b0,2'b10,1'b0,1'b0,1'b0,32'h12345678,32'h7F800000,1'b1,1'b0,4'b0101}, // R3
    {1'b1,1'b1,1'b0,2'b10,1'b0,1'b0,1'b0,32'h12345678,32'hFF7FFFFF,1'b1,1'b0,4'b0101}, // R3
    {1'b0,1'b1,1'b0,2'b11,1'b0,1'b0,1'b0,32'h12345678,32'h7F7FFFFF,1'b1,1'b0,4'b0101}, // R3
    {1'b1,1'b1,1'b0,2'b11,1'b0,1'b0,1'b0,32'h12345678,32'hFF800000,1'b1,1'b0,4'b0101}, // R3
    {1'b0,1'b1,1'b0,2'b01,1'b1,1'b0,1'b0,32'h12345678,32'h00000000,1'b0,1'b1,4'b0001}, // R5
    {1'b0,1'b0,1'b1,2'b00,1'b0,1'b0,1'b1,32'h00012345,32'h00000000,1'b1,1'b0,4'b0010}, // R6
    {1'b1,1'b0,1'b1,2'b00,1'b0,1'b0,1'b1,32'h80012345,32'h80000000,1'b1,1'b0,4'b0010}, // R6
    {1'b0,1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,32'h00012345,32'h00000000,1'b0,1'b1,4'b1010}, // R7
    {1'b1,1'b0,1'b1,2'b00,1'b0,1'b1,1'b1,32'h80012345,32'h00000000,1'b0,1'b1,4'b0010}, // R8
    {1'b1,1'b1,1'b1,2'b01,1'b0,1'b0,1'b1,32'h12345678,32'hFF7FFFFF,1'b1,1'b0,4'b0101}  // R9
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_sign = v.s; in_ovf = v.o; in_udf = v.u; rnd_mode = v.m;
    ovf_trap_en = v.oe; udf_trap_en = v.ue; flush_dn = v.dn; in_data = v.d;
    in_valid = 1'b1;
  endtask

  task automatic clear_flags();
    @(negedge clk) flags_clr = 1'b1;
    @(negedge clk) flags_clr = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R12 out_valid", {31'b0, out_valid}, 32'd0);
    check("R12 flags", {28'b0, flags}, 32'd0);
    check("R12 trap/we", {30'b0, trap_req, out_we}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      clear_flags();
      drive(VECS[i]);
      @(negedge clk) in_valid = 1'b0;
      check($sformatf("R1 v%0d out_valid", i), {31'b0, out_valid}, 32'd1);
      check($sformatf("R4/R5 v%0d we", i), {31'b0, out_we}, {31'b0, VECS[i].xwe});
      if (VECS[i].xwe)
        check($sformatf("R3/R6 v%0d data", i), out_data, VECS[i].xd);
      check($sformatf("R11 v%0d trap", i), {31'b0, trap_req}, {31'b0, VECS[i].xtr});
      check($sformatf("R7/R10 v%0d flags", i), {28'b0, flags}, {28'b0, VECS[i].xf});
      @(negedge clk);
      check($sformatf("R11 v%0d trap drop", i), {31'b0, trap_req}, 32'd0);
    end

    // R1: back-pressure
    clear_flags();
    out_ready = 1'b0;
    drive(VECS[0]); in_data = 32'h11111111;
    @(negedge clk);
    check("R1 not ready when stalled", {31'b0, in_ready}, 32'd0);
    in_data = 32'h22222222;
    @(negedge clk);
    check("R1 held data", out_data, 32'h11111111);
    check("R1 held valid", {31'b0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk) in_valid = 1'b0;
    check("R1 second taken on drain", out_data, 32'h22222222);
    @(negedge clk);
    check("R1 drained", {31'b0, out_valid}, 32'd0);

    // R10: sticky accumulation, clear, and clear colliding with a set
    clear_flags();
    drive(VECS[2]);
    @(negedge clk) drive(VECS[0]);
    @(negedge clk) drive(VECS[11]);
    @(negedge clk) in_valid = 1'b0;
    check("R10 accumulate", {28'b0, flags}, 32'b0111);
    flags_clr = 1'b1;
    drive(VECS[13]);
    @(negedge clk) begin in_valid = 1'b0; flags_clr = 1'b0; end
    check("R10 set wins over clear", {28'b0, flags}, 32'b1010);
    clear_flags();
    check("R10 clear", {28'b0, flags}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule